// File: doc/BRIEF.md
# Branch Target and Link Unit

This unit produces the next program counter for unconditional control transfers in a 32-bit core. The decoder gives it the address of the branch instruction, a branch kind code, the raw immediate field, the value of the selected address register, and a flag that tells whether the instruction is 16 or 32 bits long. One clock later the unit presents the new PC together with a taken strobe.

The kinds are plain jumps, jumps that also write a return address, calls, returns and returns from exception. Each of the first three groups can take its target in three ways: a signed 24-bit halfword displacement from the PC, a 24-bit absolute field spread over the address, or an address register. A short 16-bit form adds a signed 8-bit displacement. For link-type kinds the unit also drives a write enable and the return address for the return-address register. For calls and returns it raises a strobe that tells an external engine to save or restore the upper register context.

Top module: `brlink_unit`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: A branch is accepted on a rising clock edge when `br_valid` is 1 and `br_kind` is in 1..12. The outputs show the result after that edge, with `taken` high, and drop back after the next edge unless another branch is accepted there.
- R3: Kinds 1 (jump), 4 (jump-and-link) and 7 (call) are relative. The target is `pc` plus the signed 24-bit value `imm` multiplied by two, modulo 2^32.
- R4: Kind 12 (short jump) takes the target as `pc` plus the signed value `imm[7:0]` multiplied by two. The bits `imm[23:8]` are ignored.
- R5: Kinds 2, 5 and 8 are absolute. Target bits 31:28 are `imm[23:20]`, bits 20:1 are `imm[19:0]`, and bits 27:21 and bit 0 are zero.
- R6: Kinds 3, 6 and 9 (indirect jump, jump-and-link, call), 10 (return) and 11 (return from exception) take `ind_addr` as the target, with bit 0 forced to zero.
- R7: For kinds 4 to 9, `link_we` is 1 and `link_val` is `pc+2` when `is_short` is 1, and `pc+4` otherwise. For every other accepted kind, `link_we` and `link_val` are both zero.
- R8: `save_req` is 1 only for accepted kinds 7, 8 and 9.
- R9: `restore_req` is 1 only for accepted kinds 10 and 11.
- R10: A cycle with `br_valid` low, or with `br_kind` equal to 0, 13, 14 or 15, sets every output to zero after the next edge, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_valid | input | 1 | A decoded branch is present this cycle |
| br_kind | input | 4 | Branch kind code (see R2 to R10) |
| imm | input | 24 | Immediate field from the instruction |
| ind_addr | input | 32 | Value of the selected address register |
| pc | input | 32 | Address of the branch instruction |
| is_short | input | 1 | 1 for a 16-bit instruction, 0 for a 32-bit instruction |
| taken | output | 1 | One-cycle strobe for an accepted branch |
| pc_next | output | 32 | New program counter, zero when not taken |
| link_we | output | 1 | Write strobe for the return-address register |
| link_val | output | 32 | Return address, zero when not written |
| save_req | output | 1 | Request to save the upper context |
| restore_req | output | 1 | Request to restore the upper context |

## Verification
The bench aims at the sign boundaries of both displacement widths. It uses the most negative and most positive 24-bit values, and short displacements with stray upper bits set. A design that zero-extended the displacement, forgot the halfword shift, or used the wrong field for the short form would jump to the wrong address. Absolute fields with all bits set show whether bits 27:21 stay clear. Odd register values show whether bit 0 of indirect targets is cleared. Link values are checked for both instruction lengths and at the top of the address space, where the sum wraps. Unused kind codes, dropped valids and runs of back-to-back branches catch strobes that stick high, fire for the wrong kind, or leave stale addresses on the outputs.

// File: rtl/brlink_unit.sv
module brlink_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        br_valid,
  input  logic [3:0]  br_kind,
  input  logic [23:0] imm,
  input  logic [31:0] ind_addr,
  input  logic [31:0] pc,
  input  logic        is_short,
  output logic        taken,
  output logic [31:0] pc_next,
  output logic        link_we,
  output logic [31:0] link_val,
  output logic        save_req,
  output logic        restore_req
);
  localparam logic [3:0] K_J_REL   = 4'd1;
  localparam logic [3:0] K_J_ABS   = 4'd2;
  localparam logic [3:0] K_J_IND   = 4'd3;
  localparam logic [3:0] K_JL_REL  = 4'd4;
  localparam logic [3:0] K_JL_ABS  = 4'd5;
  localparam logic [3:0] K_JL_IND  = 4'd6;
  localparam logic [3:0] K_CA_REL  = 4'd7;
  localparam logic [3:0] K_CA_ABS  = 4'd8;
  localparam logic [3:0] K_CA_IND  = 4'd9;
  localparam logic [3:0] K_RET     = 4'd10;
  localparam logic [3:0] K_RFE     = 4'd11;
  localparam logic [3:0] K_J_SHORT = 4'd12;

  wire [31:0] tgt_rel   = pc + {{7{imm[23]}}, imm, 1'b0};
  wire [31:0] tgt_short = pc + {{23{imm[7]}}, imm[7:0], 1'b0};
  wire [31:0] tgt_abs   = {imm[23:20], 7'd0, imm[19:0], 1'b0};
  wire [31:0] tgt_ind   = {ind_addr[31:1], 1'b0};
  wire [31:0] ret_addr  = pc + (is_short ? 32'd2 : 32'd4);

  logic        go;
  logic [31:0] tgt;
  logic        lnk, sav, rst_ctx;

  always_comb begin
    go      = br_valid;
    tgt     = '0;
    lnk     = 1'b0;
    sav     = 1'b0;
    rst_ctx = 1'b0;
    case (br_kind)
      K_J_REL:   tgt = tgt_rel;
      K_J_ABS:   tgt = tgt_abs;
      K_J_IND:   tgt = tgt_ind;
      K_JL_REL:  begin tgt = tgt_rel; lnk = 1'b1; end
      K_JL_ABS:  begin tgt = tgt_abs; lnk = 1'b1; end
      K_JL_IND:  begin tgt = tgt_ind; lnk = 1'b1; end
      K_CA_REL:  begin tgt = tgt_rel; lnk = 1'b1; sav = 1'b1; end
      K_CA_ABS:  begin tgt = tgt_abs; lnk = 1'b1; sav = 1'b1; end
      K_CA_IND:  begin tgt = tgt_ind; lnk = 1'b1; sav = 1'b1; end
      K_RET,
      K_RFE:     begin tgt = tgt_ind; rst_ctx = 1'b1; end
      K_J_SHORT: tgt = tgt_short;
      default:   go = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken       <= 1'b0;
      pc_next     <= '0;
      link_we     <= 1'b0;
      link_val    <= '0;
      save_req    <= 1'b0;
      restore_req <= 1'b0;
    end else begin
      taken       <= go;
      pc_next     <= go ? tgt : '0;
      link_we     <= go & lnk;
      link_val    <= (go & lnk) ? ret_addr : '0;
      save_req    <= go & sav;
      restore_req <= go & rst_ctx;
    end
  end
endmodule

// File: rtl/brlink_unit_chk.sv
module brlink_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        br_valid,
  input logic [3:0]  br_kind,
  input logic [23:0] imm,
  input logic [31:0] ind_addr,
  input logic [31:0] pc,
  input logic        is_short,
  input logic        taken,
  input logic [31:0] pc_next,
  input logic        link_we,
  input logic [31:0] link_val,
  input logic        save_req,
  input logic        restore_req
);
  wire in_ok = br_valid && (br_kind >= 4'd1) && (br_kind <= 4'd12);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ok |=> taken);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ok |=> (!taken && pc_next == 32'd0 && link_val == 32'd0 && !link_we && !save_req && !restore_req));

  assert_abs_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ok && (br_kind == 4'd2 || br_kind == 4'd5 || br_kind == 4'd8)) |=> (pc_next[27:21] == 7'd0));

  assert_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (pc_next[0] == 1'b0));

  assert_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (taken && link_val == $past(pc) + ($past(is_short) ? 32'd2 : 32'd4)));

  assert_save_R8: assert property (@(posedge clk) disable iff (!rst_n)
    save_req |-> (taken && link_we && !restore_req));

  assert_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req |-> (taken && !link_we && !save_req));

  always @(posedge clk) begin
    assert_reset_R1: assert (rst_n || (!taken && !link_we && !save_req && !restore_req));
  end
endmodule

bind brlink_unit brlink_unit_chk chk_i (.*);

// File: tb/brlink_unit_tb_top.sv
`timescale 1ns/1ps
module brlink_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic [3:0]  br_kind = 4'd0;
  logic [23:0] imm = '0;
  logic [31:0] ind_addr = '0;
  logic [31:0] pc = '0;
  logic        is_short = 1'b0;
  logic        taken, link_we, save_req, restore_req;
  logic [31:0] pc_next, link_val;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  brlink_unit dut_i (.*);

  function automatic logic [31:0] want_target(logic [3:0] k, logic [23:0] im, logic [31:0] ia, logic [31:0] p);
    int d;
    case (k)
      4'd1, 4'd4, 4'd7: begin d = $signed({im, 8'h00}) >>> 7; return p + 32'(d); end
      4'd2, 4'd5, 4'd8: return ((32'(im) >> 20) << 28) | ((32'(im) & 32'hF_FFFF) << 1);
      4'd3, 4'd6, 4'd9, 4'd10, 4'd11: return ia & ~32'd1;
      4'd12: begin d = $signed({im[7:0], 24'h0}) >>> 23; return p + 32'(d); end
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic v, logic [3:0] k, logic [23:0] im, logic [31:0] ia, logic [31:0] p, logic sh);
    logic ok, lk;
    br_valid = v; br_kind = k; imm = im; ind_addr = ia; pc = p; is_short = sh;
    ok = v && k >= 4'd1 && k <= 4'd12;
    lk = ok && k >= 4'd4 && k <= 4'd9;
    @(negedge clk);
    chk(ok ? "R2 taken" : "R10 taken", 32'(taken), 32'(ok));
    chk(ok ? "R3/R4/R5/R6 pc_next" : "R10 pc_next", pc_next, ok ? want_target(k, im, ia, p) : 32'd0);
    chk("R7 link_we", 32'(link_we), 32'(lk));
    chk("R7 link_val", link_val, lk ? p + (sh ? 32'd2 : 32'd4) : 32'd0);
    chk("R8 save_req", 32'(save_req), 32'(ok && k >= 4'd7 && k <= 4'd9));
    chk("R9 restore_req", 32'(restore_req), 32'(ok && (k == 4'd10 || k == 4'd11)));
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    br_valid = 1'b1; br_kind = 4'd4;
    repeat (3) @(negedge clk);
    chk("R1 taken", 32'(taken), 0);
    chk("R1 pc_next", pc_next, 0);
    chk("R1 link_we", 32'(link_we), 0);
    chk("R1 save_req", 32'(save_req), 0);
    br_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    run(1, 4'd1, 24'h80_0000, 0, 32'h0100_0000, 0);
    run(1, 4'd4, 24'h7F_FFFF, 0, 32'hFF00_0000, 0);
    run(1, 4'd7, 24'hFF_FFFF, 0, 32'h0000_0000, 1);
    run(1, 4'd12, 24'hAB_CD80, 0, 32'h0000_1000, 1);
    run(1, 4'd12, 24'hFF_FF7F, 0, 32'h0000_1000, 1);
    run(1, 4'd2, 24'hFF_FFFF, 0, 32'h1234_5678, 0);
    run(1, 4'd8, 24'h50_0001, 0, 32'h0, 0);
    run(1, 4'd3, 0, 32'hDEAD_BEEF, 32'h4, 1);
    run(1, 4'd10, 24'hFF_FFFF, 32'h8000_0001, 32'h40, 1);
    run(1, 4'd11, 0, 32'h0000_0003, 32'h44, 0);
    run(1, 4'd9, 0, 32'h7, 32'hFFFF_FFFE, 1);
    run(1, 4'd6, 0, 32'h9, 32'hFFFF_FFFC, 0);
    run(0, 4'd7, 24'h12_3456, 32'h5, 32'h80, 0);
    run(1, 4'd0, 24'h1, 32'h5, 32'h80, 0);
    run(1, 4'd13, 24'h1, 32'h5, 32'h80, 0);
    run(1, 4'd15, 24'h1, 32'h5, 32'h80, 1);
    run(1, 4'd5, 24'h0F_0F0F, 0, 32'h200, 1);
    run(1, 4'd5, 24'h0F_0F0F, 0, 32'h200, 0);
    run(0, 4'd0, 0, 0, 0, 0);

    for (int i = 0; i < 400; i++) begin
      run(($urandom % 8) != 0, 4'($urandom_range(0, 15)), 24'($urandom),
          $urandom, $urandom & ~32'd1, 1'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule